// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block produces the system reset for a processor. It merges three causes of reset into one output, which it drives in both polarities at once. The causes are a digital supply-low flag from an external voltage comparator, a pushbutton wired active low, and a watchdog that software must keep alive by toggling a strobe line. Every reset is stretched so that it lasts at least a fixed number of clock cycles after its last cause has gone away.

The pushbutton and strobe are asynchronous. Each passes through a two-flop synchronizer, and the button is also debounced. The watchdog runs only while reset is inactive. A falling edge on the strobe restarts it. Its timeout is one of three lengths, picked by a 2-bit select input. All durations are parameters in clock cycles, so the same block can serve a real clock and a short simulation. A synchronous power-on clear starts the block in reset, as though a supply-low event had just ended.

Top module: `rstSupervisor`

## Requirements
- R1: `rstOutN` is always the inverse of `rstOut`.
- R2: While `porClear` is high, `rstOut` is 1. After `porClear` falls, `rstOut` goes low on the STRETCH_CYC-th rising edge at which `porClear` is low, and it stays high until that edge.
- R3: A high `supplyLow` on any rising edge makes `rstOut` high after that edge. Once `supplyLow` is low, `rstOut` goes low on the STRETCH_CYC-th rising edge at which no cause is active, counting the first edge that samples `supplyLow` low.
- R4: After synchronization, the pushbutton level is accepted only when it has differed from the accepted level on DEBOUNCE_CYC consecutive edges. A low pulse shorter than that has no effect on `rstOut`.
- R5: A press that is held long enough keeps `rstOut` high for as long as it lasts. The stretch starts when the debounced button returns high. Counted from a release driven between edges, `rstOut` is high on the next DEBOUNCE_CYC+STRETCH_CYC+1 samples.
- R6: When no strobe falling edge occurs, the watchdog raises `rstOut` on the L-th rising edge after the edge that ended reset. L is WD_SHORT for `wdSel`=0, WD_MID for 1, WD_LONG for 2, and WD_MID for the reserved value 3.
- R7: A high-to-low transition of `strobe` restarts the watchdog count. It takes effect on the third edge after the input falls. A steady level, high or low, and a rising edge do not restart it.
- R8: A watchdog reset keeps `rstOut` high for exactly STRETCH_CYC cycles. The watchdog does not count while reset is active. It restarts from zero when reset ends.
- R9: When several causes overlap, `rstOut` goes low only STRETCH_CYC edges after the last of them has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porClear | input | 1 | Synchronous power-on clear, active high |
| supplyLow | input | 1 | Supply-low flag from the comparator, synchronous to clk |
| pushBtnN | input | 1 | Pushbutton, active low, asynchronous |
| strobe | input | 1 | Watchdog strobe, asynchronous |
| wdSel | input | 2 | Watchdog timeout select: 0 short, 1 mid, 2 long, 3 mid |
| rstOut | output | 1 | Reset, active high |
| rstOutN | output | 1 | Reset, active low |

## Verification
The bench measures the length of each reset and each watchdog interval in exact cycles. It does this after power-on clear, after a supply-low pulse, and for all four select values. Together these runs tell apart the stretch count, the timeout mux and the reserved select code. A short button glitch is set against a long press, which separates the debounce threshold from the release-timed stretch. A strobe that toggles fast enough, followed by a strobe held steady high, shows that only falling edges rearm the watchdog. An overlap of supply-low and button checks that reset ends only after the last cause has cleared. A behavioural model is compared with both outputs on every cycle.

// File: rtl/rstSupPkg.sv
package rstSupPkg;
  typedef struct packed {
    logic holdExt;     // supply-low or debounced button pressed
    logic strobeFall;  // one-cycle pulse on a synchronized strobe falling edge
  } ctrlStrobes_t;
endpackage

// File: rtl/rstSupSync.sv
module rstSupSync #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             porClear,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    logic stage1, stage2;
    always_ff @(posedge clk) begin
      if (porClear) begin
        stage1 <= RESET_VAL[i];
        stage2 <= RESET_VAL[i];
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end
endmodule

// File: rtl/rstSupCtrl.sv
module rstSupCtrl
  import rstSupPkg::*;
#(
  parameter int DEBOUNCE_CYC = 10000
) (
  input  logic         clk,
  input  logic         porClear,
  input  logic         supplyLow,
  input  logic         pushBtnN,
  input  logic         strobe,
  output ctrlStrobes_t strobes
);
  localparam int DBW = $clog2(DEBOUNCE_CYC + 1);
  localparam logic [DBW-1:0] DB_LAST = DBW'(DEBOUNCE_CYC - 1);

  logic [1:0] syncVec;
  logic pbSync, stSync, stDly, pbStable;
  logic [DBW-1:0] dbCnt;

  // bit 0 button (idle high), bit 1 strobe (idle low)
  rstSupSync #(.WIDTH(2), .RESET_VAL(2'b01)) uSync (
    .clk(clk), .porClear(porClear),
    .asyncIn({strobe, pushBtnN}), .syncOut(syncVec)
  );
  assign pbSync = syncVec[0];
  assign stSync = syncVec[1];

  always_ff @(posedge clk) begin
    if (porClear) begin
      pbStable <= 1'b1;
      dbCnt    <= '0;
      stDly    <= 1'b0;
    end else begin
      stDly <= stSync;
      if (pbSync != pbStable) begin
        if (dbCnt == DB_LAST) begin
          pbStable <= pbSync;
          dbCnt    <= '0;
        end else begin
          dbCnt <= dbCnt + 1'b1;
        end
      end else begin
        dbCnt <= '0;
      end
    end
  end

  always_comb begin
    strobes.holdExt    = supplyLow | ~pbStable;
    strobes.strobeFall = stDly & ~stSync;
  end

  AST_DEB_ACCEPT: assert property (@(posedge clk) disable iff (porClear)
    (pbStable != $past(pbStable)) |-> (pbStable == $past(pbSync))); // R4
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (porClear)
    strobes.strobeFall |=> !strobes.strobeFall); // R7
endmodule

// File: rtl/rstSupDatapath.sv
module rstSupDatapath
  import rstSupPkg::*;
#(
  parameter int STRETCH_CYC = 250000,
  parameter int WD_SHORT    = 150000,
  parameter int WD_MID      = 600000,
  parameter int WD_LONG     = 1200000
) (
  input  logic         clk,
  input  logic         porClear,
  input  ctrlStrobes_t strobes,
  input  logic [1:0]   wdSel,
  output logic         rstActive
);
  localparam int WD_MAX0 = (WD_SHORT > WD_MID) ? WD_SHORT : WD_MID;
  localparam int WD_MAX  = (WD_MAX0 > WD_LONG) ? WD_MAX0 : WD_LONG;
  localparam int WDW     = $clog2(WD_MAX + 1);
  localparam int STW     = $clog2(STRETCH_CYC + 1);
  localparam logic [STW-1:0] ST_LOAD = STW'(STRETCH_CYC);

  logic [STW-1:0] stretchCnt;
  logic [WDW-1:0] wdCnt, wdLimit;
  logic wdExpire, holdReq;

  always_comb begin
    case (wdSel)
      2'd0:    wdLimit = WDW'(WD_SHORT);
      2'd2:    wdLimit = WDW'(WD_LONG);
      default: wdLimit = WDW'(WD_MID);  // 1 and reserved 3
    endcase
  end

  assign rstActive = (stretchCnt != '0);
  // >= so that lowering the select mid-count expires at once
  assign wdExpire  = !rstActive && !strobes.strobeFall && (wdCnt >= wdLimit - 1'b1);
  assign holdReq   = strobes.holdExt | wdExpire;

  always_ff @(posedge clk) begin
    if (porClear) begin
      stretchCnt <= ST_LOAD;
      wdCnt      <= '0;
    end else begin
      if (holdReq)        stretchCnt <= ST_LOAD;
      else if (rstActive) stretchCnt <= stretchCnt - 1'b1;
      if (rstActive || strobes.strobeFall || wdExpire) wdCnt <= '0;
      else                                             wdCnt <= wdCnt + 1'b1;
    end
  end

  AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (porClear)
    strobes.holdExt |=> rstActive); // R3
  AST_END_QUIET: assert property (@(posedge clk) disable iff (porClear)
    $fell(rstActive) |-> !$past(strobes.holdExt)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (porClear)
    !rstActive |-> (wdCnt < WDW'(WD_MAX))); // R6
  AST_EXPIRE_RESTART: assert property (@(posedge clk) disable iff (porClear)
    wdExpire |=> (rstActive && wdCnt == '0)); // R8
endmodule

// File: rtl/rstSupervisor.sv
module rstSupervisor
  import rstSupPkg::*;
#(
  parameter int STRETCH_CYC  = 250000,
  parameter int DEBOUNCE_CYC = 10000,
  parameter int WD_SHORT     = 150000,
  parameter int WD_MID       = 600000,
  parameter int WD_LONG      = 1200000
) (
  input  logic       clk,
  input  logic       porClear,
  input  logic       supplyLow,
  input  logic       pushBtnN,
  input  logic       strobe,
  input  logic [1:0] wdSel,
  output logic       rstOut,
  output logic       rstOutN
);
  ctrlStrobes_t ctrlStrobes;
  logic rstActive;

  rstSupCtrl #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) uCtrl (
    .clk(clk), .porClear(porClear), .supplyLow(supplyLow),
    .pushBtnN(pushBtnN), .strobe(strobe), .strobes(ctrlStrobes)
  );

  rstSupDatapath #(
    .STRETCH_CYC(STRETCH_CYC), .WD_SHORT(WD_SHORT),
    .WD_MID(WD_MID), .WD_LONG(WD_LONG)
  ) uDp (
    .clk(clk), .porClear(porClear), .strobes(ctrlStrobes),
    .wdSel(wdSel), .rstActive(rstActive)
  );

  assign rstOut  = rstActive;
  assign rstOutN = ~rstActive;
endmodule

// File: tb/sim_rstSupervisor.sv
`timescale 1ns/100ps
module sim_rstSupervisor;
  localparam int S  = 20;
  localparam int DB = 5;
  localparam int WS = 30;
  localparam int WM = 60;
  localparam int WL = 90;

  logic clk = 1'b0;
  logic porClear, supplyLow, pushBtnN, strobe;
  logic [1:0] wdSel;
  logic rstOut, rstOutN;
  int total = 0, failed = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  rstSupervisor #(.STRETCH_CYC(S), .DEBOUNCE_CYC(DB), .WD_SHORT(WS),
                  .WD_MID(WM), .WD_LONG(WL)) u0 (
    .clk(clk), .porClear(porClear), .supplyLow(supplyLow), .pushBtnN(pushBtnN),
    .strobe(strobe), .wdSel(wdSel), .rstOut(rstOut), .rstOutN(rstOutN));

  // behavioural reference: pipeline of samples, counters as integers
  int mPb[2], mSt[2], mStD, mPbStable, mDb, mStretch, mWd;
  always @(posedge clk) begin
    if (porClear) begin
      mPb = '{1, 1}; mSt = '{0, 0}; mStD = 0;
      mPbStable = 1; mDb = 0; mStretch = S; mWd = 0;
    end else begin
      bit fall, act, expire, hold;
      int lim;
      fall = (mStD == 1) && (mSt[1] == 0);
      act  = mStretch > 0;
      lim  = (wdSel == 0) ? WS : (wdSel == 2) ? WL : WM;
      expire = !act && !fall && (mWd >= lim - 1);
      hold = supplyLow || (mPbStable == 0) || expire;
      if (mPb[1] != mPbStable) begin
        if (mDb == DB - 1) begin mPbStable = mPb[1]; mDb = 0; end
        else mDb++;
      end else mDb = 0;
      mStretch = hold ? S : (act ? mStretch - 1 : 0);
      mWd = (act || fall || expire) ? 0 : mWd + 1;
      mStD = mSt[1]; mSt[1] = mSt[0]; mSt[0] = int'(strobe);
      mPb[1] = mPb[0]; mPb[0] = int'(pushBtnN);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(rstOut === (mStretch != 0), "R6 model compare", int'(rstOut), int'(mStretch != 0));
      check(rstOutN === ~rstOut, "R1 polarity", int'(rstOutN), int'(~rstOut));
    end
  end

  // number of consecutive samples equal to val; stops on the first differing sample
  task automatic runLen(input logic val, output int n);
    n = 0;
    @(negedge clk);
    while (rstOut === val && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic waitN(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic finishRun;
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    int n;
    int lims[4];
    lims = '{WS, WM, WL, WM};
    porClear = 1; supplyLow = 0; pushBtnN = 1; strobe = 0; wdSel = 2'd0;
    waitN(4);
    check(rstOut === 1'b1 && rstOutN === 1'b0, "R2 reset state", int'(rstOut), 1);
    porClear = 0;
    runLen(1'b1, n); check(n == S - 1, "R2 stretch after clear", n, S - 1);
    runLen(1'b0, n); check(n + 1 == WS, "R6 sel0 timeout", n + 1, WS);
    runLen(1'b1, n); check(n + 1 == S, "R8 watchdog reset length", n + 1, S);
    runLen(1'b0, n); check(n + 1 == WS, "R8 watchdog restart", n + 1, WS);
    // the terminating sample above is the first high one of a watchdog reset
    for (int s = 1; s < 4; s++) begin
      wdSel = 2'(s);
      supplyLow = 1;
      waitN(3);
      check(rstOut === 1'b1, "R3 active under supply low", int'(rstOut), 1);
      supplyLow = 0;
      runLen(1'b1, n); check(n == S - 1, "R3 stretch after supply low", n, S - 1);
      runLen(1'b0, n); check(n + 1 == lims[s], "R6 timeout per select", n + 1, lims[s]);
      runLen(1'b1, n); check(n + 1 == S, "R8 watchdog reset length", n + 1, S);
    end
    // R4: glitch shorter than the debounce window
    wdSel = 2'd2;
    pushBtnN = 0; waitN(DB - 2); pushBtnN = 1;
    n = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (rstOut !== 1'b0) n++; end
    check(n == 0, "R4 glitch ignored", n, 0);
    // R7: falling edges every 40 cycles keep the watchdog quiet
    n = 0;
    for (int i = 0; i < 10; i++) begin
      strobe = 1;
      for (int j = 0; j < 20; j++) begin @(negedge clk); if (rstOut !== 1'b0) n++; end
      strobe = 0;
      for (int j = 0; j < 20; j++) begin @(negedge clk); if (rstOut !== 1'b0) n++; end
    end
    check(n == 0, "R7 strobe edges rearm", n, 0);
    strobe = 1;  // rising edge and steady high: no rearm
    runLen(1'b0, n); check(n == 72, "R7 steady high no clear", n, 72);
    runLen(1'b1, n); check(n + 1 == S, "R8 watchdog reset length", n + 1, S);
    // R5: long press, stretch counted from release
    pushBtnN = 0; waitN(40);
    check(rstOut === 1'b1, "R5 active while held", int'(rstOut), 1);
    pushBtnN = 1;
    runLen(1'b1, n); check(n == DB + S + 1, "R5 stretch from release", n, DB + S + 1);
    // R9: overlapping supply low and button
    supplyLow = 1; pushBtnN = 0; waitN(30);
    pushBtnN = 1; waitN(30);
    check(rstOut === 1'b1, "R9 held by remaining source", int'(rstOut), 1);
    supplyLow = 0;
    runLen(1'b1, n); check(n == S - 1, "R9 stretch after last source", n, S - 1);
    waitN(3);
    finishRun();
  end
endmodule